// File: doc/BRIEF.md
# I2C Master STOP Sequencer with Bus-Collision Detection

This block produces the STOP condition for an I2C master that shares its bus with other masters, and it watches both lines while it does so. Software raises a one-cycle stop request. The block pulls SDA low and releases SCL only after SDA reads low. It honours clock stretching by waiting until SCL really reads high, and then releases SDA. Each hold time is set by a 7-bit reload value that a down-counter counts to zero.

SDA is checked after it has been released and the last interval has run out. SCL is watched from the moment it reads high until SDA rises. If another master holds SDA low, or pulls SCL low too early, the block sets a sticky collision flag, releases both pins, and ends the sequence without reporting completion. Both pins are open-drain: a drive output of 1 pulls the line low, and 0 lets it float high. The line inputs pass through a two-stage synchronizer before any decision uses them.

Top module: `i2c_stop_gen`

## Requirements
- R1: After reset, sda_drive, scl_drive, stop_busy, stop_done, irq and bcol are all 0.
- R2: A stop_req sampled while stop_busy is 0 sets stop_busy, sda_drive and scl_drive to 1 at that clock edge. With SDA free to go low, scl_drive returns to 0 exactly reload+4 rising edges after the one that accepted the request.
- R3: sda_drive returns to 0 exactly reload+3 rising edges after the first rising edge at which scl_in is high. sda_drive is never 0 while scl_drive is 1.
- R4: If neither line is disturbed, the sequence ends max(reload,2)+1 rising edges after the edge at which sda_drive fell. At that edge irq goes to 1 for exactly one cycle, stop_done goes to 1, stop_busy goes to 0 and both drives are 0.
- R5: If SDA still reads low when the final interval ends, bcol goes to 1, stop_busy goes to 0, both drives go to 0, irq stays 0 and stop_done stays 0.
- R6: If scl_in goes low after it has been seen high and before SDA has been seen high, the sequence aborts. This is detected on the third rising edge after scl_in falls, with the same outcome as in R5.
- R7: Once bcol is 1 it stays 1 through later sequences, successful ones included, until a bcol_clr pulse clears it at the next edge.
- R8: A stop_req while stop_busy is 1 is ignored. The timing of the sequence in progress is unchanged, and only one irq pulse is produced.
- R9: SCL held low by another device after release (stretching) is not a collision. It only delays the SDA release as given in R3.
- R10: stop_done is cleared at the edge that accepts a new stop_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | One-cycle request to start a STOP sequence |
| reload | input | 7 | Count loaded into the interval counter |
| bcol_clr | input | 1 | Clears the collision flag |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| sda_drive | output | 1 | 1 pulls SDA low |
| scl_drive | output | 1 | 1 pulls SCL low |
| stop_busy | output | 1 | Stop-enable bit; clears itself when the sequence ends |
| stop_done | output | 1 | STOP completed without collision |
| irq | output | 1 | One-cycle interrupt request on completion |
| bcol | output | 1 | Sticky bus-collision flag |

## Verification
The hardest case to reach is the SCL drop during the final interval, while SDA has been released but still reads low. A held-low SDA triggers the other collision check anyway, so the two cases can only be told apart by timing. The bench uses a long reload value, holds SDA low from outside, and pulls SCL low on the cycle SDA is released. It then requires the abort exactly three edges later, well before the interval would have run out. The SCL drop during the high-hold interval and the stretch delay are placed by counting cycles from the observed SCL release in the same way.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_WAIT,
    ST_HOLD_LOW,
    ST_SCL_WAIT,
    ST_HOLD_HIGH,
    ST_SDA_CHECK
  } stop_state_t;

  // Count used for the final interval: it must cover the synchronizer
  // latency so that the released SDA level has reached the sampler.
  function automatic int unsigned check_load(int unsigned rel, int unsigned stages);
    return (rel < stages) ? stages : rel;
  endfunction

  // Edges from a counter load to the edge that acts on its expiry.
  function automatic int unsigned interval_edges(int unsigned load_val);
    return load_val + 1;
  endfunction

endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
  import i2c_stop_pkg::*;
#(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_req,
  input  logic [W-1:0] reload,
  input  logic         sda_s,
  input  logic         scl_s,
  input  logic         tick,
  output logic         load,
  output logic [W-1:0] load_val,
  output stop_state_t  state,
  output logic         done_evt,
  output logic         coll_evt
);
  stop_state_t nxt;
  logic [W-1:0] chk_val;

  assign chk_val = W'(check_load(int'(reload), STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = reload;
    done_evt = 1'b0;
    coll_evt = 1'b0;
    case (state)
      ST_IDLE:      if (stop_req) nxt = ST_SDA_WAIT;
      ST_SDA_WAIT:  if (!sda_s) begin
                      load = 1'b1;
                      nxt  = ST_HOLD_LOW;
                    end
      ST_HOLD_LOW:  if (tick) nxt = ST_SCL_WAIT;
      ST_SCL_WAIT:  if (scl_s) begin
                      load = 1'b1;
                      nxt  = ST_HOLD_HIGH;
                    end
      ST_HOLD_HIGH: if (!scl_s) begin
                      coll_evt = 1'b1;
                      nxt      = ST_IDLE;
                    end else if (tick) begin
                      load     = 1'b1;
                      load_val = chk_val;
                      nxt      = ST_SDA_CHECK;
                    end
      ST_SDA_CHECK: if (!scl_s && !sda_s) begin
                      coll_evt = 1'b1;
                      nxt      = ST_IDLE;
                    end else if (tick) begin
                      coll_evt = !sda_s;
                      done_evt = sda_s;
                      nxt      = ST_IDLE;
                    end
      default:      nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen
  import i2c_stop_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                bcol_clr,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_drive,
  output logic                scl_drive,
  output logic                stop_busy,
  output logic                stop_done,
  output logic                irq,
  output logic                bcol
);
  logic                sda_s, scl_s, tick, load;
  logic [RELOAD_W-1:0] load_val;
  logic                done_evt, coll_evt;
  stop_state_t         state;

  i2c_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));
  i2c_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

  i2c_baud_cnt #(.W(RELOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .tick(tick));

  i2c_stop_fsm #(.W(RELOAD_W), .STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
    .sda_s(sda_s), .scl_s(scl_s), .tick(tick), .load(load),
    .load_val(load_val), .state(state), .done_evt(done_evt),
    .coll_evt(coll_evt));

  assign stop_busy = (state != ST_IDLE);
  assign sda_drive = (state == ST_SDA_WAIT) || (state == ST_HOLD_LOW) ||
                     (state == ST_SCL_WAIT) || (state == ST_HOLD_HIGH);
  assign scl_drive = (state == ST_SDA_WAIT) || (state == ST_HOLD_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_done <= 1'b0;
      irq       <= 1'b0;
      bcol      <= 1'b0;
    end else begin
      irq <= done_evt;
      if (done_evt)                              stop_done <= 1'b1;
      else if (stop_req && state == ST_IDLE)     stop_done <= 1'b0;
      if (coll_evt)      bcol <= 1'b1;
      else if (bcol_clr) bcol <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_stop_chk.sv
module i2c_stop_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic bcol_clr,
  input logic sda_drive,
  input logic scl_drive,
  input logic stop_busy,
  input logic stop_done,
  input logic irq,
  input logic bcol,
  input logic done_evt,
  input logic coll_evt
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_busy && stop_req) |=> (stop_busy && sda_drive && scl_drive && !stop_done));

  assert_pin_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_drive |-> !scl_drive);

  assert_done_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq && stop_done && !stop_busy && !sda_drive && !scl_drive));

  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_coll_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> (bcol && !irq && !stop_done && !stop_busy && !sda_drive && !scl_drive));

  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && coll_evt));

  assert_bcol_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bcol && !bcol_clr) |=> bcol);
endmodule

bind i2c_stop_gen i2c_stop_chk u_chk (.*);

// File: tb/i2c_stop_gen_bench.sv
`timescale 1ns/1ps
module i2c_stop_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0;
  logic [6:0] reload = '0;
  logic       bcol_clr = 1'b0;
  logic       ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic       sda_drive, scl_drive, stop_busy, stop_done, irq, bcol;
  logic       sda_in, scl_in;

  int tests = 0, fails = 0;
  int cyc = 0;
  int t_sda_rise, t_scl_fall, t_sda_fall, t_irq, t_busy_fall, irq_cnt = 0;
  bit p_sda = 0, p_scl = 0, p_busy = 0;
  bit finished = 0;

  assign sda_in = !(sda_drive || ext_sda_low);
  assign scl_in = !(scl_drive || ext_scl_low);

  always #2.5 clk = !clk;

  i2c_stop_gen u_i2c_stop_gen (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
    .bcol_clr(bcol_clr), .sda_in(sda_in), .scl_in(scl_in),
    .sda_drive(sda_drive), .scl_drive(scl_drive), .stop_busy(stop_busy),
    .stop_done(stop_done), .irq(irq), .bcol(bcol));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (sda_drive && !p_sda) t_sda_rise = cyc;
    if (!sda_drive && p_sda) t_sda_fall = cyc;
    if (!scl_drive && p_scl) t_scl_fall = cyc;
    if (!stop_busy && p_busy) t_busy_fall = cyc;
    if (irq) begin t_irq = cyc; irq_cnt++; end
    p_sda = sda_drive; p_scl = scl_drive; p_busy = stop_busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int max2(input int a);
    return (a < 2) ? 2 : a;
  endfunction

  task automatic wait_for(ref int stamp, input int after);
    for (int i = 0; i < 2000 && stamp < after; i++) @(negedge clk);
  endtask

  // mode 0 normal, 1 SDA held low, 2 SCL drop in high hold,
  // 3 SCL drop after SDA release with SDA held, 4 normal with extra request
  task automatic do_stop(input int r, input int s, input int mode);
    int g, e, f, irq0;
    reload = 7'(r);
    ext_scl_low = (s > 0);
    t_sda_rise = -1; t_scl_fall = -1; t_sda_fall = -1; t_irq = -1; t_busy_fall = -1;
    irq0 = irq_cnt;
    @(negedge clk);
    stop_req = 1'b1; g = cyc + 1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(t_sda_rise == g && scl_drive, "R2 drive start", t_sda_rise, g);
    chk(stop_done == 1'b0 && stop_busy, "R10 done cleared", stop_done, 0);
    if (mode == 1 || mode == 3) ext_sda_low = 1'b1;
    wait_for(t_scl_fall, g);
    e = t_scl_fall;
    chk(e == g + r + 4, "R2 scl release", e, g + r + 4);
    if (mode == 4) begin stop_req = 1'b1; @(negedge clk); stop_req = 1'b0; end
    if (s > 0) begin
      while (cyc < e + s) @(negedge clk);
      ext_scl_low = 1'b0;
    end
    if (mode == 2) begin
      while (cyc < e + s + 2) @(negedge clk);
      ext_scl_low = 1'b1;
      wait_for(t_busy_fall, g);
      chk(t_busy_fall == e + s + 5, "R6 scl drop in high hold", t_busy_fall, e + s + 5);
    end else begin
      wait_for(t_sda_fall, g);
      f = t_sda_fall;
      chk(f == e + s + r + 4, "R3 sda release", f, e + s + r + 4);
      if (mode == 3) ext_scl_low = 1'b1;
      wait_for(t_busy_fall, g);
      if (mode == 3)
        chk(t_busy_fall == f + 3, "R6 scl drop before sda high", t_busy_fall, f + 3);
      else if (mode == 1)
        chk(t_busy_fall == f + max2(r) + 1, "R5 abort time", t_busy_fall, f + max2(r) + 1);
      else begin
        chk(t_irq == f + max2(r) + 1, "R4 completion time", t_irq, f + max2(r) + 1);
        chk(t_busy_fall == t_irq, "R4 busy clears", t_busy_fall, t_irq);
      end
    end
    @(negedge clk);
    if (mode == 0 || mode == 4) begin
      chk(irq_cnt == irq0 + 1, (mode == 4) ? "R8 single irq" : "R4 single irq", irq_cnt, irq0 + 1);
      chk(stop_done && !irq && !sda_drive && !scl_drive, "R4 final state", stop_done, 1);
      if (s > 0) chk(!bcol, "R9 stretch no collision", bcol, 0);
    end else begin
      chk(bcol, (mode == 1) ? "R5 bcol set" : "R6 bcol set", bcol, 1);
      chk(irq_cnt == irq0 && !stop_done, "R5 no completion", irq_cnt - irq0, 0);
      chk(!sda_drive && !scl_drive && !stop_busy, "R5 pins released", sda_drive, 0);
    end
    ext_sda_low = 1'b0; ext_scl_low = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_bcol();
    bcol_clr = 1'b1; @(negedge clk); bcol_clr = 1'b0;
    chk(!bcol, "R7 clear", bcol, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!sda_drive && !scl_drive, "R1 pins", sda_drive, 0);
    chk(!stop_busy, "R1 busy", stop_busy, 0);
    chk(!stop_done && !irq && !bcol, "R1 flags", bcol, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!stop_busy && !sda_drive, "R1 idle after reset", stop_busy, 0);

    for (int r = 0; r < 10; r++) begin
      do_stop(r, 0, 0);
      do_stop(r, 3, 0);
    end
    do_stop(127, 0, 0);
    do_stop(5, 17, 0);

    for (int r = 0; r < 5; r++) begin
      do_stop(r, 0, 1);
      clear_bcol();
    end
    for (int r = 1; r < 6; r++) begin
      do_stop(r, r - 1, 2);
      clear_bcol();
    end
    do_stop(10, 0, 3);
    do_stop(40, 2, 3);

    do_stop(6, 0, 0);
    chk(bcol, "R7 sticky after good stop", bcol, 1);
    clear_bcol();
    do_stop(4, 2, 4);
    do_stop(0, 0, 4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule